// File: doc/BRIEF.md
# Proximity Card Command Controller

This block is the command controller on the card side of an ISO/IEC 14443 Type A proximity link. A frame decoder upstream delivers each reader frame as a command byte, an argument byte and four identifier bytes, with a flag that says whether the frame was encrypted. The controller steps through the card activation sequence: it answers a request or a wakeup, returns the identifier during anticollision at one or two cascade levels, and acknowledges a select with a card type code. It then passes authentication requests to an external engine, forwards memory commands to the memory unit and handles halt.

An external authentication engine reports its result as a single strobe with a pass or fail bit. Memory commands are accepted only once that engine has reported a pass. They must arrive encrypted and must address the sector that was authenticated. A 7-byte identifier takes two cascade levels and a 4-byte identifier takes one; the parameter `UID_BYTES` selects which. Every output is registered and appears one clock after the frame or strobe that causes it.

Top module: `picc_cmd_ctrl`

## Requirements
- R1: After reset `state` is IDLE, and `authed`, `tx_valid`, `auth_req` and `mem_go` are low. State codes: IDLE=0, READY1=1, READY2=2, ACTIVE=3, AUTH=4, HALT=5.
- R2: In IDLE, a request (command 0x26) or a wakeup (0x52) moves the card to READY1 and returns the answer-to-request code `ATQA` as 2 bytes, low byte first in `tx_data[7:0]`. Any other frame in IDLE gets no response and leaves the state unchanged.
- R3: In HALT only a wakeup (0x52) moves the card to READY1 with the answer-to-request code. A request (0x26) is ignored and the card stays in HALT with no response.
- R4: An anticollision frame (0x93 at level 1, 0x95 at level 2, argument 0x20) returns 5 bytes: four identifier bytes followed by their XOR check byte. Level 1 of a 7-byte identifier is 0x88 followed by identifier bytes 0 to 2. Level 2 carries bytes 3 to 6. A 4-byte identifier sends bytes 0 to 3 at level 1. Identifier byte 0 sits at `UID[7:0]`.
- R5: A select frame (same command, argument 0x70) whose `rx_uid` matches the four level bytes returns a 1-byte acknowledge. At the last level this is `SAK` and the card moves to ACTIVE. At level 1 of a 7-byte identifier it is 0x04 and the card moves to READY2.
- R6: Any other frame in READY1, READY2 or ACTIVE, including a select with a mismatching identifier, gets no response. The card goes to IDLE, or to HALT if it was woken from HALT.
- R7: In ACTIVE, or in AUTH with an encrypted frame, an authenticate command (0x60 key A, 0x61 key B) pulses `auth_req` for one cycle. It gives `auth_key` (0 for A, 1 for B) and the block number in `auth_blk`, sends no response and keeps the state.
- R8: A strobe on `auth_done` while in ACTIVE or AUTH moves the card to AUTH with `authed` high if `auth_ok` is set. Otherwise the card goes to IDLE with `authed` low.
- R9: Read 0x30, write 0xA0, decrement 0xC0, increment 0xC1, restore 0xC2 and transfer 0xB0 pulse `mem_go` with `mem_cmd` and `mem_addr` only in AUTH, only when encrypted, and only when the block lies in the authenticated sector (block >> 2). A wrong sector sends the card to IDLE with `authed` low. In ACTIVE these commands fall under R6.
- R10: In AUTH, unencrypted frames are ignored, including a halt. An encrypted halt (0x50, argument 0x00) moves the card to HALT and clears `authed`. Any other encrypted frame moves it to IDLE. In ACTIVE a plain halt moves the card to HALT.
- R11: When an authentication strobe that R8 honours falls in the same cycle as a frame, the strobe is handled and the frame is dropped with no response and no memory pulse.
- R12: Responses and pulses appear exactly one clock after the frame that causes them and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a decoded frame is present |
| rx_cmd | input | 8 | Command byte |
| rx_arg | input | 8 | Argument byte (NVB or block number) |
| rx_uid | input | 32 | Identifier bytes carried by a select, byte 0 low |
| rx_enc | input | 1 | Frame arrived encrypted |
| auth_done | input | 1 | Authentication result strobe |
| auth_ok | input | 1 | Result with the strobe: 1 pass, 0 fail |
| tx_valid | output | 1 | Response frame strobe |
| tx_len | output | 3 | Response length in bytes |
| tx_data | output | 40 | Response bytes, first byte low |
| auth_req | output | 1 | Start authentication pulse |
| auth_key | output | 1 | Key choice: 0 A, 1 B |
| auth_blk | output | 8 | Block named by the authenticate command |
| mem_go | output | 1 | Memory command accepted pulse |
| mem_cmd | output | 8 | Accepted memory command code |
| mem_addr | output | 8 | Accepted memory block number |
| state | output | 3 | Current protocol state |
| authed | output | 1 | Authenticated flag |

## Verification
The authentication result strobe and a reader frame can land in the same cycle. The bench provokes this twice. The first time, a pass strobe and a stray request arrive together in ACTIVE: the card must end in AUTH with no response, although the frame alone would have sent it to IDLE. The second time, a fail strobe and a correct encrypted read arrive together in AUTH: the card must drop to IDLE and `mem_go` must stay low.

// File: rtl/picc_cmd_ctrl.sv
module picc_cmd_ctrl #(
  parameter int          UID_BYTES  = 7,
  parameter logic [55:0] UID        = 56'h66_55_44_33_22_11_04,
  parameter logic [15:0] ATQA       = 16'h0044,
  parameter logic [7:0]  SAK        = 8'h08,
  parameter int          SECT_SHIFT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_cmd,
  input  logic [7:0]  rx_arg,
  input  logic [31:0] rx_uid,
  input  logic        rx_enc,
  input  logic        auth_done,
  input  logic        auth_ok,
  output logic        tx_valid,
  output logic [2:0]  tx_len,
  output logic [39:0] tx_data,
  output logic        auth_req,
  output logic        auth_key,
  output logic [7:0]  auth_blk,
  output logic        mem_go,
  output logic [7:0]  mem_cmd,
  output logic [7:0]  mem_addr,
  output logic [2:0]  state,
  output logic        authed
);
  localparam logic [2:0] S_IDLE = 3'd0, S_RDY1 = 3'd1, S_RDY2 = 3'd2,
                         S_ACT  = 3'd3, S_AUTH = 3'd4, S_HALT = 3'd5;
  localparam logic [7:0] C_REQ = 8'h26, C_WUP = 8'h52, C_CL1 = 8'h93, C_CL2 = 8'h95,
                         C_HLT = 8'h50, C_KA = 8'h60, C_KB = 8'h61,
                         NVB_AC = 8'h20, NVB_SEL = 8'h70, SAK_MORE = 8'h04;
  localparam bit TWO_LVL = (UID_BYTES == 7);

  function automatic logic [7:0] bcc(input logic [31:0] v);
    return v[7:0] ^ v[15:8] ^ v[23:16] ^ v[31:24];
  endfunction

  logic [31:0] cl1, cl2;
  generate
    if (TWO_LVL) begin : g_two
      assign cl1 = {UID[23:0], 8'h88};
    end else begin : g_one
      assign cl1 = UID[31:0];
    end
  endgenerate
  assign cl2 = UID[55:24];

  logic       from_halt;
  logic [7:0] sect_q;

  wire is_mem  = (rx_cmd == 8'h30) || (rx_cmd == 8'hA0) || (rx_cmd == 8'hC0) ||
                 (rx_cmd == 8'hC1) || (rx_cmd == 8'hC2) || (rx_cmd == 8'hB0);
  wire is_auth = (rx_cmd == C_KA) || (rx_cmd == C_KB);
  wire is_hlt  = (rx_cmd == C_HLT) && (rx_arg == 8'h00);
  wire [7:0] arg_sect = rx_arg >> SECT_SHIFT;
  wire [2:0] fb   = from_halt ? S_HALT : S_IDLE;
  wire auth_take  = auth_done && (state == S_ACT || state == S_AUTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      from_halt <= 1'b0;
      authed    <= 1'b0;
      sect_q    <= '0;
      tx_valid  <= 1'b0;
      tx_len    <= '0;
      tx_data   <= '0;
      auth_req  <= 1'b0;
      auth_key  <= 1'b0;
      auth_blk  <= '0;
      mem_go    <= 1'b0;
      mem_cmd   <= '0;
      mem_addr  <= '0;
    end else begin
      tx_valid <= 1'b0;
      auth_req <= 1'b0;
      mem_go   <= 1'b0;
      if (auth_take) begin
        authed <= auth_ok;
        state  <= auth_ok ? S_AUTH : S_IDLE;
        if (!auth_ok) from_halt <= 1'b0;
      end else if (rx_valid) begin
        case (state)
          S_IDLE: if (rx_cmd == C_REQ || rx_cmd == C_WUP) begin
            state     <= S_RDY1;
            from_halt <= 1'b0;
            tx_valid  <= 1'b1;
            tx_len    <= 3'd2;
            tx_data   <= {24'h0, ATQA};
          end
          S_HALT: if (rx_cmd == C_WUP) begin
            state     <= S_RDY1;
            from_halt <= 1'b1;
            tx_valid  <= 1'b1;
            tx_len    <= 3'd2;
            tx_data   <= {24'h0, ATQA};
          end
          S_RDY1: begin
            if (rx_cmd == C_CL1 && rx_arg == NVB_AC) begin
              tx_valid <= 1'b1;
              tx_len   <= 3'd5;
              tx_data  <= {bcc(cl1), cl1};
            end else if (rx_cmd == C_CL1 && rx_arg == NVB_SEL && rx_uid == cl1) begin
              state    <= TWO_LVL ? S_RDY2 : S_ACT;
              tx_valid <= 1'b1;
              tx_len   <= 3'd1;
              tx_data  <= {32'h0, TWO_LVL ? SAK_MORE : SAK};
            end else begin
              state <= fb;
            end
          end
          S_RDY2: begin
            if (rx_cmd == C_CL2 && rx_arg == NVB_AC) begin
              tx_valid <= 1'b1;
              tx_len   <= 3'd5;
              tx_data  <= {bcc(cl2), cl2};
            end else if (rx_cmd == C_CL2 && rx_arg == NVB_SEL && rx_uid == cl2) begin
              state    <= S_ACT;
              tx_valid <= 1'b1;
              tx_len   <= 3'd1;
              tx_data  <= {32'h0, SAK};
            end else begin
              state <= fb;
            end
          end
          S_ACT: begin
            if (is_auth) begin
              auth_req <= 1'b1;
              auth_key <= rx_cmd[0];
              auth_blk <= rx_arg;
              sect_q   <= arg_sect;
            end else if (is_hlt) begin
              state <= S_HALT;
            end else begin
              state <= fb;
            end
          end
          S_AUTH: if (rx_enc) begin
            if (is_mem && arg_sect == sect_q) begin
              mem_go   <= 1'b1;
              mem_cmd  <= rx_cmd;
              mem_addr <= rx_arg;
            end else if (is_auth) begin
              auth_req <= 1'b1;
              auth_key <= rx_cmd[0];
              auth_blk <= rx_arg;
              sect_q   <= arg_sect;
            end else begin
              state     <= is_hlt ? S_HALT : S_IDLE;
              authed    <= 1'b0;
              from_halt <= 1'b0;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module picc_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [7:0] rx_cmd,
  input logic       rx_enc,
  input logic       auth_done,
  input logic       auth_ok,
  input logic       tx_valid,
  input logic       mem_go,
  input logic [2:0] state,
  input logic       authed
);
  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'd5); // R1
  AST_TX_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(rx_valid)); // R12
  AST_HALT_EXIT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 3'd5 && state != 3'd5) |-> ($past(rx_valid) && $past(rx_cmd) == 8'h52)); // R3
  AST_MEM_IN_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_go |-> ($past(state) == 3'd4 && $past(rx_enc))); // R9
  AST_AUTH_FAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (auth_done && !auth_ok && (state == 3'd3 || state == 3'd4)) |=> (state == 3'd0 && !authed)); // R8
  AST_HALT_ENCRYPTED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 3'd4 && state == 3'd5) |-> $past(rx_enc)); // R10
  AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (auth_done && rx_valid && (state == 3'd3 || state == 3'd4)) |=> (!tx_valid && !mem_go)); // R11
endmodule

bind picc_cmd_ctrl picc_cmd_ctrl_chk u_chk (.*);

// File: tb/tb_picc_cmd_ctrl.sv
module tb_picc_cmd_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        rx_valid = 0, rx_enc = 0, auth_done = 0, auth_ok = 0;
  logic [7:0]  rx_cmd = 0, rx_arg = 0;
  logic [31:0] rx_uid = 0;
  logic        tx_valid, auth_req, auth_key, mem_go, authed;
  logic [2:0]  tx_len, state;
  logic [39:0] tx_data;
  logic [7:0]  auth_blk, mem_cmd, mem_addr;

  picc_cmd_ctrl dut (.clk, .rst_n, .rx_valid, .rx_cmd, .rx_arg, .rx_uid, .rx_enc,
    .auth_done, .auth_ok, .tx_valid, .tx_len, .tx_data, .auth_req, .auth_key,
    .auth_blk, .mem_go, .mem_cmd, .mem_addr, .state, .authed);

  logic        v4 = 0;
  logic [7:0]  c4 = 0, a4 = 0;
  logic [31:0] u4 = 0;
  logic        t4v, ar4, ak4, mg4, au4;
  logic [2:0]  t4l, s4;
  logic [39:0] t4d;
  logic [7:0]  ab4, mc4, ma4;

  picc_cmd_ctrl #(.UID_BYTES(4), .UID(56'h0000_00_DE_CC_BB_AA), .ATQA(16'h0004)) dut4 (
    .clk, .rst_n, .rx_valid(v4), .rx_cmd(c4), .rx_arg(a4), .rx_uid(u4), .rx_enc(1'b0),
    .auth_done(1'b0), .auth_ok(1'b0), .tx_valid(t4v), .tx_len(t4l), .tx_data(t4d),
    .auth_req(ar4), .auth_key(ak4), .auth_blk(ab4), .mem_go(mg4), .mem_cmd(mc4),
    .mem_addr(ma4), .state(s4), .authed(au4));

  int tests = 0, fails = 0;
  logic [42:0] exp_q[$];
  string       tag_q[$];
  string       cur_tag = "R1";

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_tx(input string tag, input logic [2:0] len, input logic [39:0] data);
    exp_q.push_back({len, data});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (exp_q.size() == 0) check({cur_tag, " unexpected response"}, {21'h0, tx_len, tx_data}, 64'h0);
      else begin
        logic [42:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {21'h0, tx_len, tx_data}, {21'h0, e});
      end
    end
  end

  task automatic frame(input logic [7:0] c, input logic [7:0] a, input logic [31:0] u, input logic e);
    @(negedge clk);
    rx_valid = 1; rx_cmd = c; rx_arg = a; rx_uid = u; rx_enc = e;
    @(negedge clk);
    rx_valid = 0; rx_enc = 0;
  endtask

  task automatic strobe(input logic ok);
    @(negedge clk);
    auth_done = 1; auth_ok = ok;
    @(negedge clk);
    auth_done = 0;
  endtask

  task automatic to_active(input logic [7:0] wake);
    cur_tag = "R5";
    expect_tx("R2 atqa", 3'd2, 40'h44);
    frame(wake, 8'h00, 0, 0);
    expect_tx("R5 sak cascade", 3'd1, 40'h04);
    frame(8'h93, 8'h70, 32'h22110488, 0);
    expect_tx("R5 sak final", 3'd1, 40'h08);
    frame(8'h95, 8'h70, 32'h66554433, 0);
    check("R5 active", state, 3);
  endtask

  task automatic frame4(input logic [7:0] c, input logic [7:0] a, input logic [31:0] u);
    @(negedge clk);
    v4 = 1; c4 = c; a4 = a; u4 = u;
    @(negedge clk);
    v4 = 0;
  endtask

  initial begin
    #(8 * 100000);
    check("watchdog", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 state", state, 0);
    check("R1 outputs", {authed, tx_valid, auth_req, mem_go}, 0);
    rst_n = 1;
    @(negedge clk);

    cur_tag = "R2";
    frame(8'h40, 8'h00, 0, 0);
    check("R2 ignore in idle", state, 0);
    expect_tx("R2 atqa", 3'd2, 40'h44);
    frame(8'h26, 8'h00, 0, 0);
    check("R2 ready1", state, 1);

    cur_tag = "R4";
    expect_tx("R4 cl1 uid", 3'd5, 40'hBF_22_11_04_88);
    frame(8'h93, 8'h20, 0, 0);
    check("R4 stay ready1", state, 1);
    expect_tx("R5 sak cascade", 3'd1, 40'h04);
    frame(8'h93, 8'h70, 32'h22110488, 0);
    check("R5 ready2", state, 2);
    expect_tx("R4 cl2 uid", 3'd5, 40'h44_66_55_44_33);
    frame(8'h95, 8'h20, 0, 0);
    expect_tx("R5 sak final", 3'd1, 40'h08);
    frame(8'h95, 8'h70, 32'h66554433, 0);
    check("R5 active", state, 3);

    cur_tag = "R6";
    frame(8'h30, 8'h04, 0, 0);
    check("R6 mem refused -> idle", state, 0);
    check("R9 no mem in active", mem_go, 0);

    to_active(8'h26);
    cur_tag = "R7";
    frame(8'h61, 8'h09, 0, 0);
    check("R7 auth req", {auth_req, auth_key, auth_blk}, {1'b1, 1'b1, 8'h09});
    check("R7 state kept", state, 3);
    strobe(1);
    check("R8 auth state", {state, authed}, {3'd4, 1'b1});

    cur_tag = "R9";
    frame(8'h30, 8'h0B, 0, 1);
    check("R9 read go", {mem_go, mem_cmd, mem_addr}, {1'b1, 8'h30, 8'h0B});
    frame(8'hC1, 8'h08, 0, 1);
    check("R9 incr go", {mem_go, mem_cmd, mem_addr}, {1'b1, 8'hC1, 8'h08});
    cur_tag = "R10";
    frame(8'h30, 8'h08, 0, 0);
    check("R10 plain mem ignored", {mem_go, state}, {1'b0, 3'd4});
    frame(8'h50, 8'h00, 0, 0);
    check("R10 plain halt ignored", {state, authed}, {3'd4, 1'b1});
    frame(8'h50, 8'h00, 0, 1);
    check("R10 encrypted halt", {state, authed}, {3'd5, 1'b0});

    cur_tag = "R3";
    frame(8'h26, 8'h00, 0, 0);
    check("R3 request ignored in halt", state, 5);
    expect_tx("R3 wake atqa", 3'd2, 40'h44);
    frame(8'h52, 8'h00, 0, 0);
    check("R3 woken", state, 1);
    cur_tag = "R6";
    frame(8'h93, 8'h70, 32'h12345678, 0);
    check("R6 bad select -> halt", state, 5);

    to_active(8'h52);
    frame(8'h60, 8'h04, 0, 0);
    check("R7 key A", {auth_req, auth_key}, 2'b10);
    strobe(1);
    cur_tag = "R9";
    frame(8'h30, 8'h10, 0, 1);
    check("R9 wrong sector", {mem_go, state, authed}, {1'b0, 3'd0, 1'b0});

    to_active(8'h26);
    frame(8'h60, 8'h04, 0, 0);
    strobe(0);
    check("R8 auth fail", {state, authed}, {3'd0, 1'b0});

    to_active(8'h26);
    frame(8'h60, 8'h04, 0, 0);
    cur_tag = "R11";
    @(negedge clk);
    auth_done = 1; auth_ok = 1; rx_valid = 1; rx_cmd = 8'h26; rx_arg = 0; rx_enc = 0;
    @(negedge clk);
    auth_done = 0; rx_valid = 0;
    check("R11 pass wins over frame", {state, authed, tx_valid}, {3'd4, 1'b1, 1'b0});
    @(negedge clk);
    auth_done = 1; auth_ok = 0; rx_valid = 1; rx_cmd = 8'h30; rx_arg = 8'h05; rx_enc = 1;
    @(negedge clk);
    auth_done = 0; rx_valid = 0; rx_enc = 0;
    check("R11 fail wins over read", {state, mem_go}, {3'd0, 1'b0});

    to_active(8'h26);
    cur_tag = "R10";
    frame(8'h50, 8'h00, 0, 0);
    check("R10 plain halt in active", state, 5);

    frame4(8'h26, 8'h00, 0);
    check("R2 4-byte atqa", {t4v, t4l, t4d}, {1'b1, 3'd2, 40'h04});
    frame4(8'h93, 8'h20, 0);
    check("R4 4-byte cl1", {t4v, t4l, t4d}, {1'b1, 3'd5, 40'h03_DE_CC_BB_AA});
    frame4(8'h93, 8'h70, 32'hDECCBBAA);
    check("R5 4-byte sak", {t4v, t4l, t4d, s4}, {1'b1, 3'd1, 40'h08, 3'd3});
    frame4(8'h95, 8'h20, 0);
    check("R6 4-byte level2 unexpected", {t4v, s4}, {1'b0, 3'd0});
    check("R12 pulse one cycle", {auth_req, mem_go}, 2'b00);

    repeat (3) @(negedge clk);
    check("R12 all responses seen", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule